// File: doc/BRIEF.md
# Per-pin GPIO peripheral multiplexer

This block sits between a port of general-purpose pads (32 wide by default) and the logic that uses them. Each pin can be handed to one of three peripheral functions, or kept under software control as plain bit-banged I/O. A small register bus reaches the per-pin function selects, the direction latch, the output data latch, the write-only set, clear and toggle strobes, and the pull-up enables.

Each peripheral slot supplies an output value and an output enable for every pin. The pin's synchronized input goes to all three slots whatever the select is. Reading the data address returns the live pin level after a two-flop synchronizer; writing that address loads the output latch. A test port injects set, clear and toggle strobes alongside the bus, so that all three can hit the same bit in one cycle.

Top module: `gpio_pinmux`

## Requirements
- R1: Each pin has a 2-bit function select: 00 software I/O, 01 peripheral 1, 10 peripheral 2, 11 peripheral 3. Pin i below NPINS/2 sits at bits [2i+1:2i] of the register at address 0. Pin i from NPINS/2 upward sits at bits [2(i-NPINS/2)+1:2(i-NPINS/2)] of the register at address 1.
- R2: With select 00, pad_out takes the data latch bit and pad_oe takes the direction bit (address 2; 1 = drive, 0 = input).
- R3: With a nonzero select, pad_out and pad_oe take the chosen peripheral's output and output enable.
- R4: pad_in reaches p1_in, p2_in and p3_in after exactly two rising clock edges, for every select value.
- R5: A read of address 3 returns the synchronized pin level, not the latch. A write to address 3 loads the output latch.
- R6: A write to address 4 sets, to address 5 clears and to address 6 inverts each latch bit written as 1. Bits written as 0 stay unchanged.
- R7: The strobes tst_set, tst_clr and tst_tgl are ORed with the bus strobes. On any bit, clear wins over set, set wins over toggle, and toggle (acting on the old latch) wins over a data write.
- R8: Addresses 4, 5 and 6 read as zero. Addresses 0, 1, 2 and 7 read back the values last written.
- R9: After reset, all selects are 00, direction and latch are all 0, pad_oe is all 0 and all pull-ups are enabled.
- R10: pad_pue follows the pull-up enable register at address 7, one bit per pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr |
| tst_set | input | NPINS | Test set strobe per bit |
| tst_clr | input | NPINS | Test clear strobe per bit |
| tst_tgl | input | NPINS | Test toggle strobe per bit |
| p1_out | input | NPINS | Peripheral 1 output values |
| p1_oe | input | NPINS | Peripheral 1 output enables |
| p1_in | output | NPINS | Synchronized pins to peripheral 1 |
| p2_out | input | NPINS | Peripheral 2 output values |
| p2_oe | input | NPINS | Peripheral 2 output enables |
| p2_in | output | NPINS | Synchronized pins to peripheral 2 |
| p3_out | input | NPINS | Peripheral 3 output values |
| p3_oe | input | NPINS | Peripheral 3 output enables |
| p3_in | output | NPINS | Synchronized pins to peripheral 3 |
| pad_in | input | NPINS | Sampled pad levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pue | output | NPINS | Pad pull-up enables |

## Verification
The hardest case to reach is the same latch bit being hit by clear, set and toggle in one cycle. The bus addresses only one strobe register per write, so it cannot produce this. The stimulus drives the three test strobes with overlapping masks, chosen so that every combination occurs on some bit. It then compares the latch, seen through pad_out with select 00 and direction set, against the priority rule. A second subtle case is the data address, which reads the pad rather than the latch. The bench drives pad_in with a pattern different from the latch so that the two sources cannot be confused.

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] tst_set,
  input  logic [NPINS-1:0] tst_clr,
  input  logic [NPINS-1:0] tst_tgl,
  input  logic [NPINS-1:0] p1_out,
  input  logic [NPINS-1:0] p1_oe,
  output logic [NPINS-1:0] p1_in,
  input  logic [NPINS-1:0] p2_out,
  input  logic [NPINS-1:0] p2_oe,
  output logic [NPINS-1:0] p2_in,
  input  logic [NPINS-1:0] p3_out,
  input  logic [NPINS-1:0] p3_oe,
  output logic [NPINS-1:0] p3_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pue
);

  localparam logic [AW-1:0] A_SELLO = AW'(0);
  localparam logic [AW-1:0] A_SELHI = AW'(1);
  localparam logic [AW-1:0] A_DIR   = AW'(2);
  localparam logic [AW-1:0] A_DAT   = AW'(3);
  localparam logic [AW-1:0] A_SET   = AW'(4);
  localparam logic [AW-1:0] A_CLR   = AW'(5);
  localparam logic [AW-1:0] A_TGL   = AW'(6);
  localparam logic [AW-1:0] A_PUE   = AW'(7);

  logic [NPINS-1:0] sel_lo, sel_hi, dir_q, lat_q, pue_q, sync1, sync2;
  logic [NPINS-1:0] set_v, clr_v, tgl_v, base, lat_d;
  logic [2*NPINS-1:0] sel_all;

  assign sel_all = {sel_hi, sel_lo};

  assign set_v = tst_set | ((bus_we && bus_addr == A_SET) ? bus_wdata : '0);
  assign clr_v = tst_clr | ((bus_we && bus_addr == A_CLR) ? bus_wdata : '0);
  assign tgl_v = tst_tgl | ((bus_we && bus_addr == A_TGL) ? bus_wdata : '0);
  assign base  = (bus_we && bus_addr == A_DAT) ? bus_wdata : lat_q;
  assign lat_d = (((base & ~tgl_v) | (~lat_q & tgl_v)) | set_v) & ~clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo <= '0;
      sel_hi <= '0;
      dir_q  <= '0;
      lat_q  <= '0;
      pue_q  <= '1;
      sync1  <= '0;
      sync2  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      lat_q <= lat_d;
      if (bus_we) begin
        case (bus_addr)
          A_SELLO: sel_lo <= bus_wdata;
          A_SELHI: sel_hi <= bus_wdata;
          A_DIR:   dir_q  <= bus_wdata;
          A_PUE:   pue_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_SELLO: bus_rdata = sel_lo;
      A_SELHI: bus_rdata = sel_hi;
      A_DIR:   bus_rdata = dir_q;
      A_DAT:   bus_rdata = sync2;
      A_PUE:   bus_rdata = pue_q;
      default: bus_rdata = '0;
    endcase
  end

  assign p1_in   = sync2;
  assign p2_in   = sync2;
  assign p3_in   = sync2;
  assign pad_pue = pue_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] sel;
    assign sel = sel_all[2*i +: 2];
    assign pad_out[i] = (sel == 2'd0) ? lat_q[i] : (sel == 2'd1) ? p1_out[i] :
                        (sel == 2'd2) ? p2_out[i] : p3_out[i];
    assign pad_oe[i]  = (sel == 2'd0) ? dir_q[i] : (sel == 2'd1) ? p1_oe[i] :
                        (sel == 2'd2) ? p2_oe[i] : p3_oe[i];
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic no_tst;
  assign no_tst = ~|{tst_set, tst_clr, tst_tgl};

  assert_sync_two_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (p1_in == $past(pad_in, 2)));

  assert_set_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET && no_tst) |=> (lat_q == ($past(lat_q) | $past(bus_wdata))));

  assert_clr_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR && no_tst) |=> (lat_q == ($past(lat_q) & ~$past(bus_wdata))));

  assert_tgl_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_TGL && no_tst) |=> (lat_q == ($past(lat_q) ^ $past(bus_wdata))));

  assert_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|tst_clr) |=> ((lat_q & $past(tst_clr)) == '0));

  assert_set_over_tgl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tst_set & ~tst_clr)) |=> ((lat_q & $past(tst_set & ~tst_clr)) == $past(tst_set & ~tst_clr)));

endmodule

// File: tb/gpio_pinmux_tb.sv
module gpio_pinmux_tb;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] tst_set = '0, tst_clr = '0, tst_tgl = '0;
  logic [N-1:0] p1_out = '0, p1_oe = '0, p2_out = '0, p2_oe = '0, p3_out = '0, p3_oe = '0;
  logic [N-1:0] p1_in, p2_in, p3_in, pad_in = '0, pad_out, pad_oe, pad_pue;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_lat = '0, m_dir = '0;

  always #2 clk = ~clk;

  gpio_pinmux #(.NPINS(N), .AW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tst_set(tst_set), .tst_clr(tst_clr), .tst_tgl(tst_tgl),
    .p1_out(p1_out), .p1_oe(p1_oe), .p1_in(p1_in),
    .p2_out(p2_out), .p2_oe(p2_oe), .p2_in(p2_in),
    .p3_out(p3_out), .p3_oe(p3_oe), .p3_in(p3_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pue(pad_pue));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    @(negedge clk);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    check("R9 pad_oe", pad_oe, '0);
    check("R9 pad_out", pad_out, '0);
    check("R9 pad_pue", pad_pue, '1);
    rd_check("R9 sel lo", 3'd0, '0);
    rd_check("R9 sel hi", 3'd1, '0);
    rd_check("R9 dir", 3'd2, '0);
    rd_check("R9 pue", 3'd7, '1);
  endtask

  task automatic t_gpio;
    m_dir = 32'h0000_FFFF; wr(3'd2, m_dir);
    m_lat = 32'hA5A5_1234; wr(3'd3, m_lat);
    check("R2 pad_out", pad_out, m_lat);
    check("R2 pad_oe", pad_oe, m_dir);
    rd_check("R8 dir readback", 3'd2, m_dir);
    @(negedge clk); pad_in = 32'h0F0F_0F0F;
    @(posedge clk); @(posedge clk); #1;
    rd_check("R5 dat reads pin", 3'd3, 32'h0F0F_0F0F);
  endtask

  task automatic t_strobes;
    wr(3'd4, 32'h0000_00F0); m_lat = m_lat | 32'h0000_00F0;
    check("R6 set", pad_out, m_lat);
    wr(3'd5, 32'hA000_0030); m_lat = m_lat & ~32'hA000_0030;
    check("R6 clear", pad_out, m_lat);
    wr(3'd6, 32'hFFFF_0000); m_lat = m_lat ^ 32'hFFFF_0000;
    check("R6 toggle", pad_out, m_lat);
    rd_check("R8 set reads 0", 3'd4, '0);
    rd_check("R8 clr reads 0", 3'd5, '0);
    rd_check("R8 tgl reads 0", 3'd6, '0);
  endtask

  task automatic t_priority;
    logic [N-1:0] s, c, t;
    m_dir = '1; wr(3'd2, m_dir);
    m_lat = 32'h3333_5555; wr(3'd3, m_lat);
    s = 32'h00FF_00FF; c = 32'h0F0F_0F0F; t = 32'h3C3C_FFFF;
    @(negedge clk);
    tst_set = s; tst_clr = c; tst_tgl = t;
    @(posedge clk); #1;
    tst_set = '0; tst_clr = '0; tst_tgl = '0;
    m_lat = ((m_lat ^ t) | s) & ~c;
    check("R7 clr>set>tgl", pad_out, m_lat);
    @(negedge clk);
    bus_addr = 3'd3; bus_we = 1; bus_wdata = 32'h0000_FFFF; tst_tgl = 32'h0000_000F;
    @(posedge clk); #1;
    bus_we = 0; tst_tgl = '0;
    m_lat = (32'h0000_FFFF & ~32'h0000_000F) | (~m_lat & 32'h0000_000F);
    check("R7 tgl over data write", pad_out, m_lat);
  endtask

  task automatic t_mux;
    logic [N-1:0] eo, ee;
    @(negedge clk);
    p1_out = 32'h1234_5678; p1_oe = 32'hFF00_FF00;
    p2_out = 32'h9ABC_DEF0; p2_oe = 32'h0F0F_F0F0;
    p3_out = 32'hCAFE_BABE; p3_oe = 32'h3333_CCCC;
    wr(3'd0, 32'hE4E4_E4E4);
    wr(3'd1, 32'hE4E4_E4E4);
    for (int i = 0; i < N; i++) begin
      case (i % 4)
        0: begin eo[i] = m_lat[i];  ee[i] = m_dir[i]; end
        1: begin eo[i] = p1_out[i]; ee[i] = p1_oe[i]; end
        2: begin eo[i] = p2_out[i]; ee[i] = p2_oe[i]; end
        default: begin eo[i] = p3_out[i]; ee[i] = p3_oe[i]; end
      endcase
    end
    check("R1 R3 mixed out", pad_out, eo);
    check("R1 R3 mixed oe", pad_oe, ee);
    rd_check("R8 sel lo readback", 3'd0, 32'hE4E4_E4E4);
    wr(3'd0, 32'hAAAA_AAAA);
    wr(3'd1, 32'hFFFF_FFFF);
    check("R3 p2/p3 out", pad_out, {p3_out[31:16], p2_out[15:0]});
    check("R3 p2/p3 oe", pad_oe, {p3_oe[31:16], p2_oe[15:0]});
    rd_check("R8 sel hi readback", 3'd1, '1);
  endtask

  task automatic t_sync;
    logic [N-1:0] old;
    old = pad_in;
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    check("R4 one edge still old", p1_in, old);
    @(posedge clk); #1;
    check("R4 p1 after two edges", p1_in, 32'hDEAD_BEEF);
    check("R4 p2 after two edges", p2_in, 32'hDEAD_BEEF);
    check("R4 p3 after two edges", p3_in, 32'hDEAD_BEEF);
  endtask

  task automatic t_pue;
    wr(3'd7, 32'h5A5A_0FF0);
    check("R10 pad_pue", pad_pue, 32'h5A5A_0FF0);
    rd_check("R8 pue readback", 3'd7, 32'h5A5A_0FF0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset;
    t_gpio;
    t_strobes;
    t_priority;
    t_mux;
    t_sync;
    t_pue;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule